// File: doc/BRIEF.md
# Stepped Spread-Spectrum Switching Clock Generator

This block derives the switching clock of a power converter from a fast reference clock. A period divider emits a one-cycle pulse at the start of every switching period. With spreading off, every period is the reference divided down to a 3 MHz nominal rate. With spreading on, the rate moves through eight fixed offsets: four below nominal and four above, evenly spaced, reaching ±10% at the ends. Each offset is held for a dwell time of 170 µs by default. Moving the rate in steps spreads the converter's switching energy over a band of frequencies, so less of it lands on any one tone.

The divider periods for all eight offsets are computed at elaboration from the reference frequency parameter. The offsets are visited in a triangle: up through the upper offsets, then down through the lower ones, so each change moves the rate by one table position. A new period is taken only when the running period ends, so no pulse is ever cut short. The current step index is brought out so that neighbouring logic can follow the modulation.

Top module: `ssc_clkgen`

## Requirements
- R1: During and right after a synchronous reset (`rst` high), `step_idx` equals the start index HALF_STEPS (4 by default), `sw_pulse` is high in the first cycle after reset is released, and the first period is the nominal one.
- R2: While `spread_en` is low, consecutive `sw_pulse` pulses are exactly NOM_PER = round(REF_HZ/NOM_HZ) reference cycles apart (80 by default).
- R3: Step index i maps to a frequency offset of (i−4)×2.5% for i < 4 and (i−3)×2.5% for i ≥ 4. Its period is round(REF_HZ / (NOM_HZ×(1+offset))). For the defaults, indices 0..7 give 89, 86, 84, 82, 78, 76, 74, 73 cycles.
- R4: While `spread_en` is high, `step_idx` changes exactly every DWELL_CYC = (REF_HZ/1e6)×DWELL_US reference cycles, counted from the first cycle in which `spread_en` is high.
- R5: The index sequence starts at 4, counts up to 7, turns and counts down to 0, turns and counts up again. Each change is ±1.
- R6: The length of the period that begins with a pulse is set by `spread_en` and `step_idx` in the reference cycle just before that pulse. Every period is therefore whole and equals the R2 or R3 value.
- R7: One cycle after `spread_en` is sampled low, `step_idx` is back at 4, and the dwell count restarts when spreading is enabled again.
- R8: `sw_pulse` is never high in two consecutive reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| spread_en | input | 1 | Enables stepped frequency spreading |
| sw_pulse | output | 1 | One-cycle pulse at the start of each switching period |
| step_idx | output | $clog2(2*HALF_STEPS) | Current spreading step index |

## Verification
The bench measures every interval between pulses. It compares each interval with the table value for the enable and step seen one cycle before the pulse. A design that switched period in the middle of a running period, or that used the wrong table entry, would produce intervals no table row gives. The turning points at indices 7 and 0 are exercised; a design that wrapped around instead of reversing would jump from 7 to 0. Spreading is disabled in the middle of a dwell. A design that kept its dwell count would advance early after re-enabling, and one that kept its index would resume off-nominal.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;

   // Signed offset in permille for table index i (no zero entry).
   function automatic int step_offset_pm(input int i, input int half, input int pm);
      if (i < half) return (i - half) * pm;
      else          return (i - half + 1) * pm;
   endfunction

   // Rounded divider period for a given offset in permille.
   function automatic int unsigned div_period(input longint unsigned ref_hz,
                                              input longint unsigned nom_hz,
                                              input int offs_pm);
      longint unsigned num;
      longint unsigned den;
      num = ref_hz * 64'd2000;
      den = nom_hz * longint'(1000 + offs_pm);
      return int'((num / den + 64'd1) / 64'd2);
   endfunction

endpackage

// File: rtl/ssc_step_seq.sv
`timescale 1ns/1ps
module ssc_step_seq #(
   parameter int unsigned HALF_STEPS = 4,
   parameter int unsigned DWELL_CYC  = 40800,
   localparam int unsigned STEPS = 2 * HALF_STEPS,
   localparam int unsigned IDX_W = $clog2(STEPS),
   localparam int unsigned DW_W  = $clog2(DWELL_CYC)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] START_IDX = IDX_W'(HALF_STEPS);
   localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(STEPS - 1);
   localparam logic [DW_W-1:0]  DW_LAST   = DW_W'(DWELL_CYC - 1);

   logic [DW_W-1:0] dwell_q;
   logic            rising_q;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         dwell_q  <= '0;
         idx      <= START_IDX;
         rising_q <= 1'b1;
      end else if (dwell_q == DW_LAST) begin
         dwell_q <= '0;
         if (rising_q) begin
            if (idx == TOP_IDX) begin
               idx      <= idx - 1'b1;
               rising_q <= 1'b0;
            end else begin
               idx <= idx + 1'b1;
            end
         end else begin
            if (idx == '0) begin
               idx      <= idx + 1'b1;
               rising_q <= 1'b1;
            end else begin
               idx <= idx - 1'b1;
            end
         end
      end else begin
         dwell_q <= dwell_q + 1'b1;
      end
   end

endmodule

// File: rtl/ssc_period_div.sv
`timescale 1ns/1ps
module ssc_period_div #(
   parameter int unsigned PER_W   = 7,
   parameter int unsigned NOM_PER = 80
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PER_W-1:0] next_per,
   output logic             pulse
);
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] per_q;
   logic             wrap;

   assign wrap  = (cnt_q == per_q - 1'b1);
   assign pulse = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         per_q <= PER_W'(NOM_PER);
      end else if (wrap) begin
         cnt_q <= '0;
         per_q <= next_per;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ssc_clkgen.sv
`timescale 1ns/1ps
module ssc_clkgen
   import ssc_pkg::*;
#(
   parameter int unsigned REF_HZ     = 240_000_000,
   parameter int unsigned NOM_HZ     = 3_000_000,
   parameter int unsigned HALF_STEPS = 4,
   parameter int unsigned STEP_PM    = 25,
   parameter int unsigned DWELL_US   = 170,
   localparam int unsigned STEPS     = 2 * HALF_STEPS,
   localparam int unsigned IDX_W     = $clog2(STEPS),
   localparam int unsigned DWELL_CYC = (REF_HZ / 1_000_000) * DWELL_US,
   localparam int unsigned NOM_PER   = div_period(REF_HZ, NOM_HZ, 0),
   localparam int unsigned MAX_PER   = div_period(REF_HZ, NOM_HZ, -int'(HALF_STEPS * STEP_PM)),
   localparam int unsigned MIN_PER   = div_period(REF_HZ, NOM_HZ, int'(HALF_STEPS * STEP_PM)),
   localparam int unsigned PER_W     = $clog2(MAX_PER + 1)
) (
   input  logic             clk_ref,
   input  logic             rst,
   input  logic             spread_en,
   output logic             sw_pulse,
   output logic [IDX_W-1:0] step_idx
);

   if (HALF_STEPS * STEP_PM >= 1000) begin : g_bad_span
      $error("spread span must stay below 100 percent");
   end
   if (REF_HZ % 1_000_000 != 0) begin : g_bad_ref
      $error("reference frequency must be a whole number of MHz");
   end
   if (MIN_PER < 2) begin : g_bad_ratio
      $error("reference too slow for the shortest period");
   end
   if (DWELL_CYC < 2) begin : g_bad_dwell
      $error("dwell must span at least two reference cycles");
   end

   logic [PER_W-1:0] per_tbl [STEPS];
   logic [PER_W-1:0] next_per;

   for (genvar g = 0; g < STEPS; g++) begin : g_tbl
      localparam int unsigned P = div_period(REF_HZ, NOM_HZ,
                                             step_offset_pm(g, HALF_STEPS, STEP_PM));
      assign per_tbl[g] = PER_W'(P);
   end

   assign next_per = spread_en ? per_tbl[step_idx] : PER_W'(NOM_PER);

   ssc_step_seq #(
      .HALF_STEPS(HALF_STEPS),
      .DWELL_CYC (DWELL_CYC)
   ) u_seq (
      .clk(clk_ref),
      .rst(rst),
      .en (spread_en),
      .idx(step_idx)
   );

   ssc_period_div #(
      .PER_W  (PER_W),
      .NOM_PER(NOM_PER)
   ) u_div (
      .clk     (clk_ref),
      .rst     (rst),
      .next_per(next_per),
      .pulse   (sw_pulse)
   );

endmodule

// File: rtl/ssc_clkgen_chk.sv
`timescale 1ns/1ps
module ssc_clkgen_chk #(
   parameter int unsigned IDX_W     = 3,
   parameter int unsigned START     = 4,
   parameter int unsigned DWELL_CYC = 40800,
   localparam int unsigned DW_W     = $clog2(DWELL_CYC)
) (
   input logic             clk_ref,
   input logic             rst,
   input logic             spread_en,
   input logic             sw_pulse,
   input logic [IDX_W-1:0] step_idx
);
   logic [DW_W-1:0] dw_cnt;
   logic            dw_last;

   always_ff @(posedge clk_ref) begin
      if (rst || !spread_en)              dw_cnt <= '0;
      else if (dw_cnt == DW_W'(DWELL_CYC - 1)) dw_cnt <= '0;
      else                                 dw_cnt <= dw_cnt + 1'b1;
   end
   assign dw_last = (dw_cnt == DW_W'(DWELL_CYC - 1));

   // R7: disabling returns the index to the start step
   a_r7_disable_home: assert property (@(posedge clk_ref) disable iff (rst)
      !spread_en |=> step_idx == IDX_W'(START));

   // R4: no change before the dwell ends
   a_r4_hold_dwell: assert property (@(posedge clk_ref) disable iff (rst)
      (spread_en && !dw_last) |=> $stable(step_idx));

   // R4: change exactly when the dwell ends
   a_r4_move_at_end: assert property (@(posedge clk_ref) disable iff (rst)
      (spread_en && dw_last) |=> step_idx != $past(step_idx));

   // R5: every change while spreading is one table position
   a_r5_unit_step: assert property (@(posedge clk_ref) disable iff (rst)
      (spread_en && dw_last) |=>
         (({1'b0, step_idx} == {1'b0, $past(step_idx)} + 1'b1) ||
          ({1'b0, step_idx} + 1'b1 == {1'b0, $past(step_idx)})));

   // R8: pulse is one cycle wide
   a_r8_single_pulse: assert property (@(posedge clk_ref) disable iff (rst)
      sw_pulse |=> !sw_pulse);

endmodule

bind ssc_clkgen ssc_clkgen_chk #(
   .IDX_W    (IDX_W),
   .START    (HALF_STEPS),
   .DWELL_CYC(DWELL_CYC)
) u_chk (
   .clk_ref  (clk_ref),
   .rst      (rst),
   .spread_en(spread_en),
   .sw_pulse (sw_pulse),
   .step_idx (step_idx)
);

// File: tb/tb_ssc_clkgen.sv
`timescale 1ns/1ps
module tb_ssc_clkgen;
   localparam int REF   = 240_000_000;
   localparam int NOM   = 3_000_000;
   localparam int HALF  = 4;
   localparam int PM    = 25;
   localparam int DUS   = 1;
   localparam int DWELL = (REF / 1_000_000) * DUS;
   localparam int START = HALF;
   localparam int IW    = $clog2(2 * HALF);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en  = 1'b0;
   logic          pulse;
   logic [IW-1:0] step;

   always #5 clk = ~clk;

   ssc_clkgen #(
      .REF_HZ(REF), .NOM_HZ(NOM), .HALF_STEPS(HALF), .STEP_PM(PM), .DWELL_US(DUS)
   ) dut (
      .clk_ref(clk), .rst(rst), .spread_en(en), .sw_pulse(pulse), .step_idx(step)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int exp_q[$];
   bit done = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // R2 / R3 expected periods from the requirement formulas
   function automatic int exp_per(input bit e, input int s);
      real f;
      int  off;
      if (!e) return $rtoi(real'(REF) / real'(NOM) + 0.5);
      off = (s < HALF) ? (s - HALF) : (s - HALF + 1);
      f = real'(NOM) * (1.0 + real'(off * PM) / 1000.0);
      return $rtoi(real'(REF) / f + 0.5);
   endfunction

   // Driver: push the R5 triangle sequence of expected indices
   task automatic push_tri(input int n);
      int s  = START;
      bit up = 1;
      for (int k = 0; k < n; k++) begin
         if (up) begin
            if (s == 2 * HALF - 1) begin s--; up = 0; end else s++;
         end else begin
            if (s == 0) begin s++; up = 1; end else s--;
         end
         exp_q.push_back(s);
      end
   endtask

   // Monitor
   longint  cyc = 0;
   longint  last_p = 0;
   bit      have = 0;
   int      exp_cur = 0;
   int      run = 0;
   bit      p_en = 0, pp_en = 0, p_pulse = 0;
   int      p_step = START;

   always @(negedge clk) begin
      cyc++;
      if (rst) begin
         have = 0; run = 0;
         p_en = en; pp_en = en; p_step = int'(step); p_pulse = 0;
      end else begin
         if (pulse) begin
            check(!p_pulse, "R8 pulse width", 1, 0);
            if (have)
               check(cyc - last_p == exp_cur, p_en ? "R3 R6 period" : "R2 R6 period",
                     int'(cyc - last_p), exp_cur);
            have    = 1;
            last_p  = cyc;
            exp_cur = exp_per(p_en, p_step);
         end
         if (int'(step) != p_step && p_en && en) begin
            if (exp_q.size() == 0) check(0, "R5 unexpected step", int'(step), -1);
            else begin
               int e;
               e = exp_q.pop_front();
               check(int'(step) == e, "R5 step order", int'(step), e);
            end
            check(run == DWELL, "R4 dwell length", run, DWELL);
         end
         if (!p_en && pp_en) check(int'(step) == START, "R7 return home", int'(step), START);
         if (!en) run = 0;
         else if (int'(step) != p_step) run = 1;
         else run++;
         pp_en = p_en; p_en = en; p_step = int'(step); p_pulse = pulse;
      end
   end

   task automatic report;
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200_000 * 10);
      check(0, "watchdog expired", 0, 1);
      report();
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check(pulse == 1'b1, "R1 first pulse", int'(pulse), 1);
      check(int'(step) == START, "R1 start index", int'(step), START);
      // R2: nominal operation
      repeat (600) @(posedge clk);
      // R3 R4 R5: full triangle including both turning points
      #1 en = 1'b1;
      push_tri(16);
      repeat (14 * DWELL + 50) @(posedge clk);
      check(exp_q.size() == 2, "R4 step count", exp_q.size(), 2);
      // R7: disable in the middle of a dwell
      #1 en = 1'b0;
      exp_q.delete();
      repeat (500) @(posedge clk);
      // R7: dwell restarts, sequence starts again from the start index
      #1 en = 1'b1;
      push_tri(4);
      repeat (2 * DWELL + DWELL / 2) @(posedge clk);
      check(exp_q.size() == 2, "R7 restart count", exp_q.size(), 2);
      #1 en = 1'b0;
      exp_q.delete();
      repeat (300) @(posedge clk);
      // R1: reset again after activity
      #1 rst = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check(pulse == 1'b1, "R1 pulse after reset", int'(pulse), 1);
      check(int'(step) == START, "R1 index after reset", int'(step), START);
      repeat (400) @(posedge clk);
      report();
   end

endmodule